// File: doc/BRIEF.md
# Two-Mode Character Command Decoder

This block sits between a serial character receiver and the parallel command interface of a daisy-wheel style printer. Each time the receiver presents a complete 7-bit character, the block decides which printer function that character calls for. It then emits a one-cycle command pulse with a command kind and an 11-bit printer data word.

The block has two modes. Text mode gives ordinary terminal behaviour: printable characters print, and a small set of control codes request carriage return with line feed, line feed, reverse line feed, half-line moves and tabbing. Incremental mode gives direct control of the mechanism. Printable characters still print. A character whose two top bits are both clear opens a two-character command: its low five bits are held, and the next character supplies six more bits. The joined 11-bit word becomes a carriage or paper motion command. One reserved control code enters incremental mode and another leaves it.

Top module: `cmdchar_decode`

## Requirements
- R1: After reset the block is in text mode (`incr_mode` = 0). `cmd_pulse`, `cmd_kind` and `cmd_word` are all zero.
- R2: A command appears only as a `cmd_pulse` that is high for one cycle. It follows the clock edge that samples `char_stb` high. In every cycle without a pulse, `cmd_kind` and `cmd_word` read zero. Kind codes: none 0, print 1, return with line feed 2, line feed 3, reverse line feed 4, half-line down 5, half-line up 6, tab 7, carriage motion 8, paper motion 9.
- R3: In text mode, a character with bit 6 or bit 5 set gives kind 1, with `cmd_word` equal to the character zero-extended.
- R4: In text mode, control codes map as follows, each with a zero word: 0x0D to kind 2, 0x0A to kind 3, 0x0B to kind 4, 0x0E to kind 5, 0x0C to kind 6, 0x09 to kind 7.
- R5: In text mode, 0x00 and every other control code not named in R4 or R6 produce no pulse and leave the mode unchanged.
- R6: In text mode, 0x0F switches to incremental mode and produces no pulse.
- R7: In incremental mode, a character with bit 6 or bit 5 set that does not complete a pair gives kind 1, with the character zero-extended as the word.
- R8: In incremental mode, a character that does not complete a pair, has bits 6 and 5 clear, and is neither 0x00 nor 0x1B produces no pulse. Its low five bits are held as the first half of a pair.
- R9: The character after a held first half always completes the pair, whatever its value. The pulse carries word = {held five bits, low six bits of the second character}. The kind is 9 when word bit 10 is 1 and 8 when it is 0. The pair is then closed.
- R10: In incremental mode, 0x1B that does not complete a pair switches back to text mode and produces no pulse.
- R11: In incremental mode, 0x00 that does not complete a pair produces no pulse and opens no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_stb | input | 1 | One-cycle trigger: a received character is valid |
| char_in | input | 7 | Received character |
| cmd_pulse | output | 1 | One-cycle command pulse |
| cmd_kind | output | 4 | Command kind code (see R2) |
| cmd_word | output | 11 | Printer data word for the command |
| incr_mode | output | 1 | 1 while in incremental mode |

## Verification
The checker watches, on every cycle, that pulses follow only a sampled trigger and that the idle outputs stay zero. It also checks that text-mode printable characters and the null code behave as required, that the mode-entry code sets the mode silently, and that motion kinds arise only out of incremental mode. Whether a pair joins the right bits depends on the character that came before. So do the choice between carriage and paper, the rule that a second character is consumed even when printable or reserved, and the return to text mode. Only the bench's directed and random sequences can show these, checked against a reference model of mode and pairing.

// File: rtl/cmdchar_pkg.sv
package cmdchar_pkg;

   typedef enum logic [3:0] {
      K_NONE  = 4'd0,
      K_PRINT = 4'd1,
      K_CRLF  = 4'd2,
      K_LF    = 4'd3,
      K_RLF   = 4'd4,
      K_SUB   = 4'd5,
      K_SUP   = 4'd6,
      K_TAB   = 4'd7,
      K_CARR  = 4'd8,
      K_PAPER = 4'd9
   } cmd_kind_t;

   localparam logic [6:0] CH_NUL        = 7'h00;
   localparam logic [6:0] CH_TAB        = 7'h09;
   localparam logic [6:0] CH_LF         = 7'h0A;
   localparam logic [6:0] CH_RLF        = 7'h0B;
   localparam logic [6:0] CH_SUP        = 7'h0C;
   localparam logic [6:0] CH_CRLF       = 7'h0D;
   localparam logic [6:0] CH_SUB        = 7'h0E;
   localparam logic [6:0] CH_ENTER_INCR = 7'h0F;
   localparam logic [6:0] CH_LEAVE_INCR = 7'h1B;

endpackage

// File: rtl/cmdchar_text_map.sv
module cmdchar_text_map
   import cmdchar_pkg::*;
#(
   parameter int CHAR_W = 7
) (
   input  logic [CHAR_W-1:0] ch,
   output cmd_kind_t         kind
);

   logic printable;
   assign printable = |ch[CHAR_W-1 -: 2];

   always_comb begin
      kind = K_NONE;
      if (printable)                        kind = K_PRINT;
      else if (ch == CHAR_W'(CH_CRLF))      kind = K_CRLF;
      else if (ch == CHAR_W'(CH_LF))        kind = K_LF;
      else if (ch == CHAR_W'(CH_RLF))       kind = K_RLF;
      else if (ch == CHAR_W'(CH_SUB))       kind = K_SUB;
      else if (ch == CHAR_W'(CH_SUP))       kind = K_SUP;
      else if (ch == CHAR_W'(CH_TAB))       kind = K_TAB;
   end

endmodule

// File: rtl/cmdchar_incr_ctl.sv
module cmdchar_incr_ctl
   import cmdchar_pkg::*;
#(
   parameter  int CHAR_W = 7,
   parameter  int HOLD_W = 5,
   parameter  int LOW_W  = 6,
   localparam int WORD_W = HOLD_W + LOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [CHAR_W-1:0] ch,
   input  cmd_kind_t         text_kind,
   output logic              mode_q,
   output logic              fire,
   output cmd_kind_t         kind,
   output logic [WORD_W-1:0] word
);

   logic              pair_q, pair_d, mode_d;
   logic [HOLD_W-1:0] hold_q, hold_d;
   logic              high_set;

   assign high_set = |ch[CHAR_W-1 -: 2];

   always_comb begin
      mode_d = mode_q;
      pair_d = pair_q;
      hold_d = hold_q;
      fire   = 1'b0;
      kind   = K_NONE;
      word   = '0;
      if (stb) begin
         if (!mode_q) begin
            if (ch == CHAR_W'(CH_ENTER_INCR)) begin
               mode_d = 1'b1;
               pair_d = 1'b0;
            end else if (text_kind != K_NONE) begin
               fire = 1'b1;
               kind = text_kind;
               if (text_kind == K_PRINT) word = WORD_W'(ch);
            end
         end else if (pair_q) begin
            fire   = 1'b1;
            pair_d = 1'b0;
            word   = {hold_q, ch[LOW_W-1:0]};
            kind   = hold_q[HOLD_W-1] ? K_PAPER : K_CARR;
         end else if (high_set) begin
            fire = 1'b1;
            kind = K_PRINT;
            word = WORD_W'(ch);
         end else if (ch == CHAR_W'(CH_LEAVE_INCR)) begin
            mode_d = 1'b0;
            pair_d = 1'b0;
         end else if (ch != CHAR_W'(CH_NUL)) begin
            pair_d = 1'b1;
            hold_d = ch[HOLD_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         pair_q <= 1'b0;
         hold_q <= '0;
      end else begin
         mode_q <= mode_d;
         pair_q <= pair_d;
         hold_q <= hold_d;
      end
   end

endmodule

// File: rtl/cmdchar_decode.sv
module cmdchar_decode
   import cmdchar_pkg::*;
#(
   parameter  int CHAR_W     = 7,
   parameter  int HOLD_W     = 5,
   parameter  int LOW_W      = 6,
   parameter  bit CLEAR_IDLE = 1'b1,
   localparam int WORD_W     = HOLD_W + LOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_stb,
   input  logic [CHAR_W-1:0] char_in,
   output logic              cmd_pulse,
   output logic [3:0]        cmd_kind,
   output logic [WORD_W-1:0] cmd_word,
   output logic              incr_mode
);

   generate
      if (CHAR_W < 7)            $error("CHAR_W must be at least 7");
      if (LOW_W >= CHAR_W)       $error("LOW_W must be below CHAR_W");
      if (HOLD_W > CHAR_W - 2)   $error("HOLD_W must fit below the two top bits");
      if (WORD_W < CHAR_W)       $error("word must hold a full character");
   endgenerate

   cmd_kind_t         text_kind, dec_kind;
   logic              dec_fire;
   logic [WORD_W-1:0] dec_word;
   logic              pulse_q;
   cmd_kind_t         kind_q;
   logic [WORD_W-1:0] word_q;

   cmdchar_text_map #(.CHAR_W(CHAR_W)) u_map (
      .ch   (char_in),
      .kind (text_kind)
   );

   cmdchar_incr_ctl #(.CHAR_W(CHAR_W), .HOLD_W(HOLD_W), .LOW_W(LOW_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (char_stb),
      .ch        (char_in),
      .text_kind (text_kind),
      .mode_q    (incr_mode),
      .fire      (dec_fire),
      .kind      (dec_kind),
      .word      (dec_word)
   );

   generate
      if (CLEAR_IDLE) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pulse_q <= 1'b0;
               kind_q  <= K_NONE;
               word_q  <= '0;
            end else begin
               pulse_q <= dec_fire;
               kind_q  <= dec_fire ? dec_kind : K_NONE;
               word_q  <= dec_fire ? dec_word : '0;
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pulse_q <= 1'b0;
               kind_q  <= K_NONE;
               word_q  <= '0;
            end else begin
               pulse_q <= dec_fire;
               if (dec_fire) begin
                  kind_q <= dec_kind;
                  word_q <= dec_word;
               end
            end
         end
      end
   endgenerate

   assign cmd_pulse = pulse_q;
   assign cmd_kind  = kind_q;
   assign cmd_word  = word_q;

endmodule

// File: rtl/cmdchar_decode_chk.sv
module cmdchar_decode_chk
   import cmdchar_pkg::*;
#(
   parameter  int CHAR_W = 7,
   parameter  int HOLD_W = 5,
   parameter  int LOW_W  = 6,
   localparam int WORD_W = HOLD_W + LOW_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_stb,
   input logic [CHAR_W-1:0] char_in,
   input logic              cmd_pulse,
   input logic [3:0]        cmd_kind,
   input logic [WORD_W-1:0] cmd_word,
   input logic              incr_mode
);

   // R2
   pulse_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse |-> $past(char_stb));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_pulse |-> (cmd_kind == 4'd0 && cmd_word == '0));

   // R6
   enter_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && !incr_mode && char_in == CHAR_W'(CH_ENTER_INCR)) |=> (incr_mode && !cmd_pulse));

   // R5
   text_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && !incr_mode && char_in == '0) |=> (!cmd_pulse && !incr_mode));

   // R3
   text_print_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && !incr_mode && (|char_in[CHAR_W-1 -: 2]))
      |=> (cmd_pulse && cmd_kind == 4'd1 && cmd_word == WORD_W'($past(char_in))));

   // R9
   motion_in_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pulse && (cmd_kind == 4'd8 || cmd_kind == 4'd9)) |-> $past(incr_mode));

endmodule

bind cmdchar_decode cmdchar_decode_chk #(.CHAR_W(CHAR_W), .HOLD_W(HOLD_W), .LOW_W(LOW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .char_stb  (char_stb),
   .char_in   (char_in),
   .cmd_pulse (cmd_pulse),
   .cmd_kind  (cmd_kind),
   .cmd_word  (cmd_word),
   .incr_mode (incr_mode)
);

// File: tb/sim_cmdchar_decode.sv
module sim_cmdchar_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        char_stb = 1'b0;
   logic [6:0]  char_in = '0;
   logic        cmd_pulse;
   logic [3:0]  cmd_kind;
   logic [10:0] cmd_word;
   logic        incr_mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   bit         m_mode = 1'b0;
   bit         m_pair = 1'b0;
   logic [4:0] m_hold = '0;

   always #10 clk = ~clk;

   cmdchar_decode u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_stb  (char_stb),
      .char_in   (char_in),
      .cmd_pulse (cmd_pulse),
      .cmd_kind  (cmd_kind),
      .cmd_word  (cmd_word),
      .incr_mode (incr_mode)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int text_kind(input logic [6:0] c);
      if (c[6:5] != 2'b00) return 1;
      case (c)
         7'h0D: return 2;
         7'h0A: return 3;
         7'h0B: return 4;
         7'h0E: return 5;
         7'h0C: return 6;
         7'h09: return 7;
         default: return 0;
      endcase
   endfunction

   task automatic model(input logic [6:0] c, output bit f, output int k,
                        output int w, output string tag);
      f = 1'b0; k = 0; w = 0; tag = "R5";
      if (!m_mode) begin
         if (c == 7'h0F) begin
            m_mode = 1'b1; m_pair = 1'b0; tag = "R6";
         end else begin
            k = text_kind(c);
            if (k == 1) begin f = 1'b1; w = int'(c); tag = "R3"; end
            else if (k != 0) begin f = 1'b1; tag = "R4"; end
         end
      end else if (m_pair) begin
         f = 1'b1; m_pair = 1'b0;
         w = int'({m_hold, c[5:0]});
         k = m_hold[4] ? 9 : 8;
         tag = "R9";
      end else if (c[6:5] != 2'b00) begin
         f = 1'b1; k = 1; w = int'(c); tag = "R7";
      end else if (c == 7'h1B) begin
         m_mode = 1'b0; tag = "R10";
      end else if (c == 7'h00) begin
         tag = "R11";
      end else begin
         m_pair = 1'b1; m_hold = c[4:0]; tag = "R8";
      end
   endtask

   task automatic send(input logic [6:0] c);
      bit f; int k; int w; string tag;
      model(c, f, k, w, tag);
      @(negedge clk);
      char_stb = 1'b1;
      char_in  = c;
      @(negedge clk);
      char_stb = 1'b0;
      chk(tag, "pulse", int'(cmd_pulse), int'(f));
      chk(tag, "kind",  int'(cmd_kind), k);
      chk(tag, "word",  int'(cmd_word), w);
      chk(tag, "mode",  int'(incr_mode), int'(m_mode));
      @(negedge clk);
      // R2: pulse lasts one cycle
      chk("R2", "pulse after idle", int'(cmd_pulse), 0);
      chk("R2", "idle kind", int'(cmd_kind), 0);
   endtask

   initial begin
      #(64'd20 * 64'd200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [6:0] ctl_codes [6] = '{7'h0D, 7'h0A, 7'h0B, 7'h0E, 7'h0C, 7'h09};
      void'($urandom(32'd20250));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "pulse", int'(cmd_pulse), 0);
      chk("R1", "mode",  int'(incr_mode), 0);
      chk("R1", "kind",  int'(cmd_kind), 0);
      chk("R1", "word",  int'(cmd_word), 0);
      rst_n = 1'b1;

      // text mode
      send(7'h41);                      // R3
      send(7'h7F);                      // R3
      for (int i = 0; i < 6; i++) send(ctl_codes[i]);   // R4
      send(7'h00);                      // R5
      send(7'h01);                      // R5
      send(7'h1B);                      // R5 in text mode
      send(7'h0F);                      // R6

      // incremental mode
      send(7'h42);                      // R7
      send(7'h00);                      // R11
      send(7'h13);                      // R8 first half, bit 4 set
      send(7'h25);                      // R9 paper motion
      send(7'h05);                      // R8
      send(7'h5A);                      // R9 printable taken as second
      send(7'h02);                      // R8
      send(7'h1B);                      // R9 reserved code taken as second
      send(7'h1F);                      // R8
      send(7'h00);                      // R9 null taken as second
      send(7'h1B);                      // R10 back to text
      send(7'h25);                      // R3 no pair left open

      // random mix
      for (int n = 0; n < 500; n++) begin
         int r;
         logic [6:0] c;
         r = int'($urandom % 16);
         if (r < 2)       c = 7'h0F;
         else if (r < 3)  c = 7'h1B;
         else if (r < 4)  c = 7'h00;
         else if (r < 9)  c = 7'($urandom % 32);
         else             c = 7'($urandom % 128);
         send(c);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule